// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

The block gathers thirty-two level-sensitive interrupt sources into four group requests for a higher-level interrupt controller. Sources are split into four groups of eight, and each group fills one byte lane of a shared 32-bit register word. Each group drives its own request line, plus a 3-bit index that names the lowest-numbered source in that group that is currently pending.

Software controls the per-source enable bits through a small memory-mapped window. A write-one-to-set register turns enables on and a write-one-to-clear register turns them off, so no read-modify-write is needed. A status word shows which enabled sources are active. Every enable starts cleared after reset.

Source lines are brought into the clock domain by a two-flop synchroniser. The masked status is held in a register, and the group requests and indices are decoded from that register.

Top module: `irq_combiner_bank`

## Requirements
- R1: A bus write to byte offset 0x0 sets every enable bit whose write-data bit is 1. Enable bits whose data bit is 0 keep their value. A read of offset 0x0 returns the 32-bit enable word.
- R2: A bus write to byte offset 0x4 clears every enable bit whose write-data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: After reset, all enable bits, all status bits, all group requests, all group indices and the read data are 0.
- R4: Status bit i is the synchronised level of source i ANDed with enable bit i. A read of byte offset 0xC returns the status word.
- R5: Group g owns bits [8g+7:8g] of the enable and status words. Its request `grp_irq_o[g]` is the OR of those eight status bits.
- R6: A group request stays asserted for as long as any enabled source in the group remains active. It drops once all such sources go inactive or are disabled.
- R7: `grp_idx_o[3g+2:3g]` holds the lowest set status bit position (0 to 7) within group g. It is 0 when the group has no set status bit.
- R8: A change on a source input that is stable before rising edge 1 reaches the status register and the group outputs at rising edge 3. An enable write taken at one rising edge affects the group outputs at the next rising edge.
- R9: Reads of any byte offset other than 0x0 and 0xC return 0. Writes to any byte offset other than 0x0 and 0x4 change nothing.
- R10: `rd_data_o` loads on the rising edge where `rd_en_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Raw interrupt source levels, active high |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 4 | Byte offset within the register window |
| wr_data_i | input | 32 | Bus write data |
| rd_data_o | output | 32 | Registered bus read data |
| grp_irq_o | output | 4 | Per-group interrupt request |
| grp_idx_o | output | 12 | Per-group lowest pending source index, 3 bits per group |

## Verification
The bench writes set and clear masks that contain zero bits. A design that treated the registers as plain stores would wipe the neighbouring enables. It drives several active sources in one group and expects the lowest position as the index; an encoder with reversed priority would report the highest. It checks the exact edge at which a source change appears, which catches a missing or an extra synchroniser stage. It also writes all-ones to the status and unmapped offsets, which exposes decoders that alias those offsets onto the enable registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_EN_SET = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'hC;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } en_acc_e;

  function automatic en_acc_e decode_write(input logic wr, input logic [ADDR_W-1:0] ofs);
    en_acc_e acc;
    acc = ACC_NONE;
    if (wr) begin
      if (ofs == OFS_EN_SET)      acc = ACC_SET;
      else if (ofs == OFS_EN_CLR) acc = ACC_CLR;
    end
    return acc;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs
  import irqc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  en_o
);
  en_acc_e          acc;
  logic [WIDTH-1:0] en_d;
  logic [WIDTH-1:0] en_q;
  logic             en_we;

  always_comb begin
    acc   = decode_write(wr_en_i, addr_i);
    en_d  = en_q;
    en_we = 1'b0;
    case (acc)
      ACC_SET: begin
        en_d  = en_q | wr_data_i;
        en_we = 1'b1;
      end
      ACC_CLR: begin
        en_d  = en_q & ~wr_data_i;
        en_we = 1'b1;
      end
      default: begin
        en_d  = en_q;
        en_we = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o = en_q;

  // R1
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_EN_SET) |=> ((en_q & $past(wr_data_i)) == $past(wr_data_i)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_EN_CLR) |=> ((en_q & $past(wr_data_i)) == '0));
  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || (addr_i != OFS_EN_SET && addr_i != OFS_EN_CLR)) |=> $stable(en_q));
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] status_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] status_d;
  logic [N_SRC-1:0] status_q;
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    status_d = lvl_i & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_comb begin
    idx_c = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (status_q[i]) idx_c = IDX_W'(i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
  assign idx_o    = idx_c;

  // R4
  stat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(en_i)) == '0));
  // R7
  idx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_q[idx_o]);
  // R7
  idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_q & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0));
  // R7
  idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (idx_o == '0));
endmodule

// File: rtl/irq_combiner_bank.sv
module irq_combiner_bank
  import irqc_pkg::*;
#(
  parameter int unsigned GROUPS    = 4,
  parameter int unsigned GROUP_SRC = 8,
  localparam int unsigned WIDTH = GROUPS * GROUP_SRC,
  localparam int unsigned IDX_W = (GROUP_SRC > 1) ? $clog2(GROUP_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        src_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WIDTH-1:0]        wr_data_i,
  output logic [WIDTH-1:0]        rd_data_o,
  output logic [GROUPS-1:0]       grp_irq_o,
  output logic [GROUPS*IDX_W-1:0] grp_idx_o
);
  logic             rst_n_s;
  logic [WIDTH-1:0] lvl_s;
  logic [WIDTH-1:0] en_w;
  logic [WIDTH-1:0] status_w;
  logic [WIDTH-1:0] rd_d;
  logic [WIDTH-1:0] rd_q;

  irqc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_n_o(rst_n_s)
  );

  irqc_sync #(.WIDTH(WIDTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d_i  (src_i),
    .q_o  (lvl_s)
  );

  irqc_enable_regs #(.WIDTH(WIDTH)) u_en (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .en_o     (en_w)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    irqc_group #(.N_SRC(GROUP_SRC)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .lvl_i   (lvl_s[g*GROUP_SRC +: GROUP_SRC]),
      .en_i    (en_w[g*GROUP_SRC +: GROUP_SRC]),
      .status_o(status_w[g*GROUP_SRC +: GROUP_SRC]),
      .irq_o   (grp_irq_o[g]),
      .idx_o   (grp_idx_o[g*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    case (addr_i)
      OFS_EN_SET: rd_d = en_w;
      OFS_STATUS: rd_d = status_w;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en_i && addr_i != OFS_EN_SET && addr_i != OFS_STATUS) |=> (rd_data_o == '0));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en_i |=> $stable(rd_data_o));
  // R5
  grp_any_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (status_w != '0) |-> (grp_irq_o != '0));
endmodule

// File: tb/irq_combiner_bank_bench.sv
`timescale 1ns/1ps
module irq_combiner_bank_bench;
  localparam int G = 4;
  localparam int S = 8;
  localparam int W = 32;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  src;
  logic          wr_en;
  logic          rd_en;
  logic [3:0]    addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic [G-1:0]  irq;
  logic [G*3-1:0] idx;

  int checks;
  int failures;
  bit done;
  logic [W-1:0] en_model;

  irq_combiner_bank u_irq_combiner_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .grp_irq_o(irq), .grp_idx_o(idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == 4'h0) en_model = en_model | d;
    else if (a == 4'h4) en_model = en_model & ~d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic apply_src(input logic [W-1:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [2:0] lowest(input logic [7:0] b);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) if (b[i]) r = 3'(i);
    return r;
  endfunction

  task automatic check_groups(input string req);
    logic [W-1:0] st;
    logic [W-1:0] rd;
    st = src & en_model;
    for (int g = 0; g < G; g++) begin
      chk({req, " R5 irq"}, W'(irq[g]), W'(|st[g*8 +: 8]));
      chk({req, " R7 idx"}, W'(idx[g*3 +: 3]), W'(lowest(st[g*8 +: 8])));
    end
    bus_read(4'hC, rd);
    chk({req, " R4 status"}, rd, st);
  endtask

  task automatic t_reset();
    logic [W-1:0] rd;
    chk("R3 rdata", rdata, '0);
    chk("R3 irq", W'(irq), '0);
    chk("R3 idx", W'(idx), '0);
    bus_read(4'h0, rd);
    chk("R3 enables", rd, '0);
    bus_read(4'hC, rd);
    chk("R3 status", rd, '0);
  endtask

  task automatic t_set_clear();
    logic [W-1:0] rd;
    bus_write(4'h0, 32'h0000_00A5);
    bus_read(4'h0, rd);
    chk("R1 set", rd, 32'h0000_00A5);
    bus_write(4'h0, 32'h0100_0000);
    bus_read(4'h0, rd);
    chk("R1 zeros keep", rd, 32'h0100_00A5);
    bus_write(4'h4, 32'h0000_0005);
    bus_read(4'h0, rd);
    chk("R2 clear", rd, 32'h0100_00A0);
    bus_write(4'h4, 32'h0000_0000);
    bus_read(4'h0, rd);
    chk("R2 zeros keep", rd, 32'h0100_00A0);
    bus_write(4'h4, 32'hFFFF_FFFF);
  endtask

  task automatic t_patterns();
    bus_write(4'h0, 32'hFFFF_FFFF);
    apply_src(32'h0000_0000); check_groups("pat0");
    apply_src(32'h8040_2010); check_groups("pat1");
    apply_src(32'h0F00_F001); check_groups("pat2");
    apply_src(32'hFFFF_FFFF); check_groups("pat3");
    bus_write(4'h4, 32'hFF00_FF00);
    @(negedge clk);
    check_groups("mask R4");
    chk("R4 masked group1 idle", W'(irq[1]), '0);
  endtask

  task automatic t_priority();
    bus_write(4'h0, 32'hFFFF_FFFF);
    apply_src(32'h2400_8000);
    chk("R7 grp3 lowest", W'(idx[11:9]), 32'd2);
    chk("R7 grp1 bit7", W'(idx[5:3]), 32'd7);
    chk("R7 grp0 none", W'(idx[2:0]), 32'd0);
    check_groups("prio");
  endtask

  task automatic t_latency_level();
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'h0000_0008);
    @(negedge clk); src = '0;
    repeat (3) @(negedge clk);
    src = 32'h0000_0008;
    repeat (2) @(negedge clk);
    chk("R8 not before edge3", W'(irq[0]), '0);
    @(negedge clk);
    chk("R8 at edge3", W'(irq[0]), 32'd1);
    chk("R8 idx", W'(idx[2:0]), 32'd3);
    repeat (10) @(negedge clk);
    chk("R6 held", W'(irq[0]), 32'd1);
    @(negedge clk); wr_en = 1'b1; addr = 4'h4; wdata = 32'h8; en_model = 0;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 enable not yet", W'(irq[0]), 32'd1);
    @(negedge clk);
    chk("R6 disabled drops", W'(irq[0]), '0);
    bus_write(4'h0, 32'h0000_0008);
    @(negedge clk);
    chk("R6 re-enabled", W'(irq[0]), 32'd1);
    apply_src(32'h0);
    chk("R6 source drop", W'(irq[0]), '0);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] rd;
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'h0000_FF00);
    apply_src(32'h0000_FF00);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_write(4'h1, 32'hFFFF_FFFF);
    bus_read(4'h0, rd);
    chk("R9 writes ignored", rd, 32'h0000_FF00);
    bus_read(4'h4, rd); chk("R9 read 0x4", rd, '0);
    bus_read(4'h8, rd); chk("R9 read 0x8", rd, '0);
    bus_read(4'hF, rd); chk("R9 read 0xF", rd, '0);
    bus_read(4'hC, rd); chk("R4 status", rd, 32'h0000_FF00);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", rdata, 32'h0000_FF00);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0; en_model = '0;
    rst_n = 1'b0; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_patterns();
    t_priority();
    t_latency_level();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule